// File: doc/BRIEF.md
# Vector Step Address Sequencer

This block produces the step address for a pattern generator or analyzer. Once the host raises the run level, it walks through vector addresses on every clock where the step enable is high, without further host involvement. The vector word read at the current address returns per-step control bits. These bits can request a jump to one of two preloaded target registers, or a pause.

An external jump line, passed through a synchronizer, can force a jump to the first target register. The line is sensed either on a rising edge or as an active-low level. A pause is either unconditional, or held only while a masked compare of the external event bus against a host-programmed pattern succeeds. The sequence wraps after the last step of the configured depth. Dropping the run level returns the address to zero.

Top module: `vec_seq`

## Requirements
- R1: During reset, step_addr is 0. Whenever run is 0 at a rising clock edge, step_addr is 0 after that edge.
- R2: While run is 1, a clock with step_en 0 leaves step_addr unchanged. A clock with step_en 1 and no jump or pause increments it by one.
- R3: An increment from address DEPTH-1 gives address 0.
- R4: With step_en 1 and no pause, ld_a loads jmp_a_addr on the next edge and ld_b loads jmp_b_addr. When both are set, ld_a wins.
- R5: With xj_edge_mode 1, a rising edge on xjump_in loads jmp_a_addr exactly once. The load happens on the third rising clock edge after the change, when step_en is high. Holding the line high or letting it fall causes no further jump.
- R6: With xj_edge_mode 0, every enabled step loads jmp_a_addr while the line, delayed by two synchronizer flops, is 0.
- R7: An external jump takes priority over any pause and over ld_a and ld_b. A pause takes priority over ld_a and ld_b.
- R8: pause_kind 2'b01 (unconditional) holds step_addr. It is left only through an external jump or through stop.
- R9: pause_kind 2'b10 (conditional) holds step_addr while ((evt_bus ^ p_event) & ~p_mask) == 0, so a mask bit of 1 ignores that bit. On a mismatch the step proceeds as with no pause, including ld_a and ld_b.
- R10: pause_kind 2'b11 acts the same as 2'b00 (no pause).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Host run level; 0 stops the sequencer and clears the address |
| step_en | input | 1 | Step clock enable |
| xj_edge_mode | input | 1 | 1: rising-edge external jump; 0: active-low level |
| jmp_a_addr | input | ADDR_W | First jump target |
| jmp_b_addr | input | ADDR_W | Second jump target |
| p_event | input | EVT_W | Pause compare pattern |
| p_mask | input | EVT_W | Pause compare mask (1 ignores the bit) |
| ld_a | input | 1 | Step control: jump to first target |
| ld_b | input | 1 | Step control: jump to second target |
| pause_kind | input | 2 | Step control: 00 none, 01 unconditional, 10 conditional, 11 none |
| evt_bus | input | EVT_W | External event bus |
| xjump_in | input | 1 | Asynchronous external jump line |
| step_addr | output | ADDR_W | Current step address |

## Verification
The only state visible at the ports is the address register, so a wrong priority or a wrong pause decision shows on step_addr after the first enabled clock. It appears as a held address where a change was due, or the reverse. Faults in the synchronizer or the edge detector appear a few cycles later. They show as a jump one edge early or late, or as repeated jumps while the line stays high. The bench therefore samples at the exact edge the requirements name.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;
   typedef enum logic [1:0] {
      PK_NONE = 2'b00,
      PK_HALT = 2'b01,
      PK_COND = 2'b10,
      PK_RSVD = 2'b11
   } pause_kind_e;
endpackage

// File: rtl/vec_seq_xsync.sv
module vec_seq_xsync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic step_en,
   input  logic edge_mode,
   input  logic xj_in,
   output logic fire
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] sync_q;
   logic         prev_q;
   logic         pend_q;
   logic         synced;
   logic         rise;

   assign synced = sync_q[TOP];
   assign rise   = synced & ~prev_q;

   // Idle level is high so that reset never looks like an active-low request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[TOP-1:0], xj_in};
         prev_q <= synced;
         pend_q <= run & edge_mode & (pend_q | rise) & ~step_en;
      end
   end

   assign fire = run & (edge_mode ? (rise | pend_q) : ~synced);
endmodule

// File: rtl/vec_seq_pause.sv
module vec_seq_pause
   import vec_seq_pkg::*;
#(
   parameter int EVT_W = 8
) (
   input  logic [EVT_W-1:0] evt_bus,
   input  logic [EVT_W-1:0] p_event,
   input  logic [EVT_W-1:0] p_mask,
   input  pause_kind_e      kind,
   output logic             hold
);
   logic [EVT_W-1:0] miss;

   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      assign miss[i] = (evt_bus[i] ^ p_event[i]) & ~p_mask[i];
   end

   always_comb begin
      unique case (kind)
         PK_HALT: hold = 1'b1;
         PK_COND: hold = ~|miss;
         default: hold = 1'b0;
      endcase
   end
endmodule

// File: rtl/vec_seq_next.sv
module vec_seq_next #(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 200
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] tgt_a,
   input  logic [ADDR_W-1:0] tgt_b,
   input  logic              ld_a,
   input  logic              ld_b,
   input  logic              fire,
   input  logic              hold,
   output logic [ADDR_W-1:0] nxt
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   always_comb begin
      if (fire)             nxt = tgt_a;
      else if (hold)        nxt = cur;
      else if (ld_a)        nxt = tgt_a;
      else if (ld_b)        nxt = tgt_b;
      else if (cur == LAST) nxt = '0;
      else                  nxt = cur + 1'b1;
   end
endmodule

// File: rtl/vec_seq.sv
module vec_seq
   import vec_seq_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DEPTH       = 200,
   parameter int EVT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              step_en,
   input  logic              xj_edge_mode,
   input  logic [ADDR_W-1:0] jmp_a_addr,
   input  logic [ADDR_W-1:0] jmp_b_addr,
   input  logic [EVT_W-1:0]  p_event,
   input  logic [EVT_W-1:0]  p_mask,
   input  logic              ld_a,
   input  logic              ld_b,
   input  logic [1:0]        pause_kind,
   input  logic [EVT_W-1:0]  evt_bus,
   input  logic              xjump_in,
   output logic [ADDR_W-1:0] step_addr
);
   if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("vec_seq: DEPTH must lie in 2 .. 2**ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vec_seq: SYNC_STAGES must be at least 2");
   end
   if (EVT_W < 1) begin : g_bad_evt
      $error("vec_seq: EVT_W must be at least 1");
   end

   logic              xj_fire;
   logic              hold;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;

   vec_seq_xsync #(.SYNC_STAGES(SYNC_STAGES)) xsync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .step_en   (step_en),
      .edge_mode (xj_edge_mode),
      .xj_in     (xjump_in),
      .fire      (xj_fire)
   );

   vec_seq_pause #(.EVT_W(EVT_W)) pause_i (
      .evt_bus (evt_bus),
      .p_event (p_event),
      .p_mask  (p_mask),
      .kind    (pause_kind_e'(pause_kind)),
      .hold    (hold)
   );

   vec_seq_next #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) next_i (
      .cur   (addr_q),
      .tgt_a (jmp_a_addr),
      .tgt_b (jmp_b_addr),
      .ld_a  (ld_a),
      .ld_b  (ld_b),
      .fire  (xj_fire),
      .hold  (hold),
      .nxt   (addr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (!run)    addr_q <= '0;
      else if (step_en) addr_q <= addr_nxt;
   end

   assign step_addr = addr_q;
endmodule

// File: rtl/vec_seq_chk.sv
module vec_seq_chk #(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 200,
   parameter int EVT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              step_en,
   input logic              ld_a,
   input logic              ld_b,
   input logic [1:0]        pause_kind,
   input logic [ADDR_W-1:0] jmp_a_addr,
   input logic [ADDR_W-1:0] jmp_b_addr,
   input logic [EVT_W-1:0]  evt_bus,
   input logic [EVT_W-1:0]  p_event,
   input logic [EVT_W-1:0]  p_mask,
   input logic              xj_fire,
   input logic [ADDR_W-1:0] step_addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic no_pause;
   assign no_pause = (pause_kind == 2'b00) || (pause_kind == 2'b11);

   p_stop_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> step_addr == '0);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run && !step_en |=> $stable(step_addr));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run && step_en && !xj_fire && no_pause && !ld_a && !ld_b && step_addr == LAST
      |=> step_addr == '0);

   p_load_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && step_en && !xj_fire && no_pause && ld_a |=> step_addr == $past(jmp_a_addr));

   p_load_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && step_en && !xj_fire && no_pause && !ld_a && ld_b
      |=> step_addr == $past(jmp_b_addr));

   p_ext_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run && step_en && xj_fire |=> step_addr == $past(jmp_a_addr));

   p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run && step_en && !xj_fire && pause_kind == 2'b01 |=> $stable(step_addr));

   p_cond_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run && step_en && !xj_fire && pause_kind == 2'b10
      && ((evt_bus ^ p_event) & ~p_mask) == '0 |=> $stable(step_addr));
endmodule

bind vec_seq vec_seq_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .EVT_W(EVT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .step_en    (step_en),
   .ld_a       (ld_a),
   .ld_b       (ld_b),
   .pause_kind (pause_kind),
   .jmp_a_addr (jmp_a_addr),
   .jmp_b_addr (jmp_b_addr),
   .evt_bus    (evt_bus),
   .p_event    (p_event),
   .p_mask     (p_mask),
   .xj_fire    (xj_fire),
   .step_addr  (step_addr)
);

// File: tb/vec_seq_tb_top.sv
module vec_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DP = 12;
   localparam int EW = 8;
   localparam int NTAB = 15;

   // entry: {ld_a, ld_b, pause_kind[1:0], evt_bus[7:0], expected_addr[3:0]}
   localparam logic [15:0] TAB [NTAB] = '{
      {1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
      {1'b0, 1'b0, 2'd0, 8'h00, 4'd2},
      {1'b0, 1'b1, 2'd0, 8'h00, 4'd3},
      {1'b1, 1'b0, 2'd0, 8'h00, 4'd9},
      {1'b0, 1'b0, 2'd0, 8'h00, 4'd10},
      {1'b0, 1'b0, 2'd0, 8'h00, 4'd11},
      {1'b0, 1'b0, 2'd0, 8'h00, 4'd0},
      {1'b1, 1'b1, 2'd0, 8'h00, 4'd9},
      {1'b0, 1'b0, 2'd1, 8'h00, 4'd9},
      {1'b0, 1'b1, 2'd1, 8'h00, 4'd9},
      {1'b0, 1'b0, 2'd2, 8'hA5, 4'd9},
      {1'b0, 1'b0, 2'd2, 8'hAA, 4'd9},
      {1'b0, 1'b0, 2'd2, 8'hB5, 4'd10},
      {1'b0, 1'b1, 2'd2, 8'hB5, 4'd3},
      {1'b0, 1'b0, 2'd3, 8'hA5, 4'd4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          step_en = 1'b1;
   logic          xj_edge_mode = 1'b1;
   logic [AW-1:0] jmp_a_addr = 4'd9;
   logic [AW-1:0] jmp_b_addr = 4'd3;
   logic [EW-1:0] p_event = 8'hA5;
   logic [EW-1:0] p_mask = 8'h0F;
   logic          ld_a = 1'b0;
   logic          ld_b = 1'b0;
   logic [1:0]    pause_kind = 2'd0;
   logic [EW-1:0] evt_bus = 8'h00;
   logic          xjump_in = 1'b0;
   logic [AW-1:0] step_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vec_seq #(.ADDR_W(AW), .DEPTH(DP), .EVT_W(EW), .SYNC_STAGES(2)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .step_en      (step_en),
      .xj_edge_mode (xj_edge_mode),
      .jmp_a_addr   (jmp_a_addr),
      .jmp_b_addr   (jmp_b_addr),
      .p_event      (p_event),
      .p_mask       (p_mask),
      .ld_a         (ld_a),
      .ld_b         (ld_b),
      .pause_kind   (pause_kind),
      .evt_bus      (evt_bus),
      .xjump_in     (xjump_in),
      .step_addr    (step_addr)
   );

   task automatic check(input logic [AW-1:0] exp, input string req);
      checks++;
      if (step_addr !== exp) begin
         failures++;
         $display("FAIL %s: step_addr=%0d expected=%0d", req, step_addr, exp);
      end
   endtask

   function automatic string tab_req(input int i);
      case (i)
         0, 1, 4, 5:  return "R2 increment";
         2, 3, 7:     return "R4 program jump";
         6:           return "R3 wrap";
         8, 9:        return "R8 unconditional pause";
         10, 11, 12, 13: return "R9 conditional pause";
         default:     return "R10 reserved kind";
      endcase
   endfunction

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      ticks(3);
      check(4'd0, "R1 reset");
      rst_n = 1'b1;
      run = 1'b1;
      for (int i = 0; i < NTAB; i++) begin
         {ld_a, ld_b, pause_kind, evt_bus} = TAB[i][15:4];
         ticks(1);
         check(TAB[i][3:0], tab_req(i));
      end
      {ld_a, ld_b, pause_kind, evt_bus} = '0;

      // R2: disabled steps hold, then one enabled step increments
      step_en = 1'b0;
      ticks(3);
      check(4'd4, "R2 hold without step_en");
      step_en = 1'b1;
      ticks(1);
      check(4'd5, "R2 increment after hold");

      // R1: stop clears the address
      run = 1'b0;
      ticks(1);
      check(4'd0, "R1 stop");

      // R5: edge mode, jump on third edge after the rise, once only
      run = 1'b1;
      xjump_in = 1'b1;
      ticks(2);
      check(4'd2, "R5 no jump before sync delay");
      ticks(1);
      check(4'd9, "R5 edge jump");
      ticks(2);
      check(4'd11, "R5 single jump while high");
      xjump_in = 1'b0;
      ticks(3);
      check(4'd2, "R5 no jump on fall");

      // R6: level mode, low synced line jumps on every step
      xj_edge_mode = 1'b0;
      ticks(1);
      check(4'd9, "R6 level jump");
      ticks(1);
      check(4'd9, "R6 level jump repeats");
      xjump_in = 1'b1;
      ticks(3);
      check(4'd10, "R6 release after sync delay");

      // R7/R8: pause holds, external jump overrides pause and ld_b
      pause_kind = 2'd1;
      ld_b = 1'b1;
      xjump_in = 1'b0;
      ticks(2);
      check(4'd10, "R8 pause holds");
      ticks(1);
      check(4'd9, "R7 external jump beats pause and ld_b");
      run = 1'b0;
      ticks(1);
      check(4'd0, "R1 stop while paused");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule